// File: doc/BRIEF.md
# Stop Mode Selection Controller

This block picks the low-power state a device enters when its processor issues a stop request, and decides how the device leaves that state. Two write-once configuration registers feed the choice. The options register holds a stop enable. The power register holds a deep-power-down bit and a partial-power-down bit. Two further inputs force the lightest stop state: one enables low-voltage detection while stopped, the other enables debug. Wake events come from the external reset pin, the IRQ pin, a keyboard interrupt pulse and a periodic timer pulse.

The block reports the current mode on a 2-bit code. On leaving a stop state it raises exactly one one-cycle result pulse:
- a power-on-style reset request, when leaving the deep states;
- a pin reset request;
- an illegal-opcode reset request, when a stop is requested without the enable;
- a resume indication, when leaving the light stop state through an interrupt.

A partial-power-down flag records that the device woke from stop2. Software clears it with an acknowledge bit carried on a power-register write.

The FSM has four states: RUN, STOP1, STOP2 and STOP3. Its transitions are:
- **ENTER**: RUN to a stop state on a granted request.
- **ILLEGAL**: RUN to RUN with a reset, when the request has no enable.
- **PIN_RESET**: RUN or STOP3 to RUN.
- **DEEP_EXIT**: STOP1 or STOP2 to RUN with a power-on-style reset.
- **RESUME**: STOP3 to RUN.
- **HOLD**: any disallowed wake leaves the state unchanged.

Top module: `stopsel_ctrl`

## Requirements
- R1: `mode` encodes 0 = run, 1 = stop1, 2 = stop2, 3 = stop3. A granted stop request selects stop1 when deep = 1 and partial = 0, stop2 when deep = 1 and partial = 1, and stop3 when deep = 0, whatever partial holds.
- R2: With `lvd_stop_en` or `dbg_en` high, a granted stop request always enters stop3, whatever the deep and partial bits hold.
- R3: A stop request in run while the stored stop enable is 0 gives a one-cycle `illop_req`. The mode stays run.
- R4: After any reset, the options register and the power register each accept only their first write. Later writes leave `cfg_stop_en`, `cfg_deep` and `cfg_partial` unchanged. Writes are taken only in run and only in a cycle with no stop request.
- R5: Stop1 is left only on a falling edge of `rst_pin_n` or of `irq_pin`. The exit raises `por_req`, returns to run and leaves `ppd_flag` at 0. Keyboard and timer pulses are ignored in stop1.
- R6: Stop2 is left on a falling edge of `rst_pin_n`, a falling edge of `irq_pin`, or a timer pulse. The exit raises `por_req`, returns to run and sets `ppd_flag`. Keyboard pulses are ignored in stop2.
- R7: In stop3 the following return to run with a one-cycle `resume`: an IRQ edge of the configured polarity (rising when `irq_pol_high` = 1, falling otherwise), a keyboard pulse, or a timer pulse. A falling edge of `rst_pin_n` instead gives `rst_req`. An IRQ edge of the other polarity is ignored.
- R8: In stop1 and stop2 the IRQ pin wakes on its falling edge even when `irq_pol_high` = 1. A rising edge there is ignored.
- R9: A power-register write with `pm_ack` = 1 clears `ppd_flag`, even after that register's write-once slot is used.
- R10: Every mode change and result pulse appears on the clock edge that samples its cause. At most one of `por_req`, `rst_req`, `illop_req` and `resume` is high at a time. In the cycle of any reset request, all configuration bits read 0. After `rst_n`, the block is in run with every output 0.
- R11: A falling edge of `rst_pin_n` in run gives `rst_req`, clears the configuration and clears `ppd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | Stop instruction executed by the processor |
| opt_wr | input | 1 | Write strobe for the options register |
| opt_stop_en | input | 1 | Stop enable data for the options register |
| pm_wr | input | 1 | Write strobe for the power register |
| pm_deep | input | 1 | Deep power-down data bit |
| pm_partial | input | 1 | Partial power-down data bit |
| pm_ack | input | 1 | Acknowledge bit that clears `ppd_flag` |
| lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| dbg_en | input | 1 | Debug mode enabled |
| irq_pol_high | input | 1 | IRQ configured for rising edges (stop3 only) |
| rst_pin_n | input | 1 | External reset pin, active low |
| irq_pin | input | 1 | External IRQ pin level |
| kbi_evt | input | 1 | Keyboard interrupt pulse |
| rti_evt | input | 1 | Periodic timer pulse |
| mode | output | 2 | Current mode code |
| por_req | output | 1 | Power-on-style reset request pulse |
| rst_req | output | 1 | Pin reset request pulse |
| illop_req | output | 1 | Illegal-opcode reset request pulse |
| resume | output | 1 | Resume-after-stop pulse |
| cfg_stop_en | output | 1 | Stored stop enable |
| cfg_deep | output | 1 | Stored deep bit |
| cfg_partial | output | 1 | Stored partial bit |
| ppd_flag | output | 1 | Woke-from-stop2 flag |

## Verification
Every result is due on the first rising edge that samples its cause. This holds for mode changes, the four result pulses, configuration loads, and the clearing or setting of the flag. Pin edges are found against the level stored at the previous edge, so a pin change made between edges acts on the next edge and on no later one. The bench changes inputs just after a rising edge and reads results one edge later, before it drives anything new. A behavioural model advances on the same edge and is compared at the falling edge of every cycle.

// File: rtl/stopsel_pkg.sv
package stopsel_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN   = 2'd0,
        MODE_STOP1 = 2'd1,
        MODE_STOP2 = 2'd2,
        MODE_STOP3 = 2'd3
    } pmode_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_DEEP_EXIT,
        EV_PIN_RESET,
        EV_ILLEGAL,
        EV_RESUME
    } pevent_t;

    typedef struct packed {
        logic stop_en;
        logic deep;
        logic partial;
    } pcfg_t;

    typedef struct packed {
        logic pin_fall;
        logic irq_fall;
        logic irq_cfg;
        logic kbi;
        logic rti;
    } pwake_t;
endpackage

// File: rtl/stopsel_wonce.sv
module stopsel_wonce #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            taken <= 1'b0;
        end else if (clr) begin
            q     <= '0;
            taken <= 1'b0;
        end else if (wr && !taken) begin
            q     <= d;
            taken <= 1'b1;
        end
    end
endmodule

// File: rtl/stopsel_cfg.sv
module stopsel_cfg
    import stopsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_allow,
    input  logic  clr_all,
    input  logic  set_flag,
    input  logic  opt_wr,
    input  logic  opt_stop_en,
    input  logic  pm_wr,
    input  logic  pm_deep,
    input  logic  pm_partial,
    input  logic  pm_ack,
    output pcfg_t cfg,
    output logic  ppd_flag
);
    localparam int PM_W = 2;

    logic [PM_W-1:0] pm_q;
    logic [0:0]      opt_q;

    stopsel_wonce #(.W(1)) u_opt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_all),
        .wr   (opt_wr && wr_allow),
        .d    (opt_stop_en),
        .q    (opt_q)
    );

    stopsel_wonce #(.W(PM_W)) u_pm (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_all),
        .wr   (pm_wr && wr_allow),
        .d    ({pm_deep, pm_partial}),
        .q    (pm_q)
    );

    always_comb begin
        cfg.stop_en = opt_q[0];
        cfg.deep    = pm_q[1];
        cfg.partial = pm_q[0];
    end

    // The flag outlives the deep-exit reset; only ack, block reset
    // or another reset request changes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ppd_flag <= 1'b0;
        end else if (clr_all) begin
            ppd_flag <= set_flag;
        end else if (wr_allow && pm_wr && pm_ack) begin
            ppd_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/stopsel_wake.sv
module stopsel_wake
    import stopsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   irq_pol_high,
    input  logic   rst_pin_n,
    input  logic   irq_pin,
    input  logic   kbi_evt,
    input  logic   rti_evt,
    output pwake_t wake
);
    logic rst_pin_q;
    logic irq_q;
    logic irq_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pin_q <= 1'b1;
            irq_q     <= 1'b1;
        end else begin
            rst_pin_q <= rst_pin_n;
            irq_q     <= irq_pin;
        end
    end

    always_comb begin
        irq_rise      = !irq_q && irq_pin;
        wake.pin_fall = rst_pin_q && !rst_pin_n;
        wake.irq_fall = irq_q && !irq_pin;
        wake.irq_cfg  = irq_pol_high ? irq_rise : wake.irq_fall;
        wake.kbi      = kbi_evt;
        wake.rti      = rti_evt;
    end
endmodule

// File: rtl/stopsel_fsm.sv
module stopsel_fsm
    import stopsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stop_req,
    input  logic   lvd_stop_en,
    input  logic   dbg_en,
    input  pcfg_t  cfg,
    input  pwake_t wake,
    output pmode_t state,
    output logic   wr_allow,
    output logic   clr_all,
    output logic   set_flag,
    output logic   por_req,
    output logic   rst_req,
    output logic   illop_req,
    output logic   resume
);
    pmode_t  state_nx;
    pmode_t  target;
    pevent_t ev;

    always_comb begin
        if (lvd_stop_en || dbg_en) begin
            target = MODE_STOP3;
        end else if (!cfg.deep) begin
            target = MODE_STOP3;
        end else if (cfg.partial) begin
            target = MODE_STOP2;
        end else begin
            target = MODE_STOP1;
        end
    end

    always_comb begin
        state_nx = state;
        ev       = EV_NONE;
        unique case (state)
            MODE_RUN: begin
                if (wake.pin_fall) begin
                    ev = EV_PIN_RESET;
                end else if (stop_req) begin
                    if (!cfg.stop_en) begin
                        ev = EV_ILLEGAL;
                    end else begin
                        state_nx = target;
                    end
                end
            end
            MODE_STOP1: begin
                if (wake.pin_fall || wake.irq_fall) begin
                    state_nx = MODE_RUN;
                    ev       = EV_DEEP_EXIT;
                end
            end
            MODE_STOP2: begin
                if (wake.pin_fall || wake.irq_fall || wake.rti) begin
                    state_nx = MODE_RUN;
                    ev       = EV_DEEP_EXIT;
                end
            end
            MODE_STOP3: begin
                if (wake.pin_fall) begin
                    state_nx = MODE_RUN;
                    ev       = EV_PIN_RESET;
                end else if (wake.irq_cfg || wake.kbi || wake.rti) begin
                    state_nx = MODE_RUN;
                    ev       = EV_RESUME;
                end
            end
            default: begin
                state_nx = MODE_RUN;
            end
        endcase
    end

    always_comb begin
        wr_allow = (state == MODE_RUN) && !stop_req;
        clr_all  = (ev == EV_DEEP_EXIT) || (ev == EV_PIN_RESET) || (ev == EV_ILLEGAL);
        set_flag = (ev == EV_DEEP_EXIT) && (state == MODE_STOP2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MODE_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_req   <= 1'b0;
            rst_req   <= 1'b0;
            illop_req <= 1'b0;
            resume    <= 1'b0;
        end else begin
            por_req   <= (ev == EV_DEEP_EXIT);
            rst_req   <= (ev == EV_PIN_RESET);
            illop_req <= (ev == EV_ILLEGAL);
            resume    <= (ev == EV_RESUME);
        end
    end
endmodule

// File: rtl/stopsel_ctrl.sv
module stopsel_ctrl
    import stopsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       opt_wr,
    input  logic       opt_stop_en,
    input  logic       pm_wr,
    input  logic       pm_deep,
    input  logic       pm_partial,
    input  logic       pm_ack,
    input  logic       lvd_stop_en,
    input  logic       dbg_en,
    input  logic       irq_pol_high,
    input  logic       rst_pin_n,
    input  logic       irq_pin,
    input  logic       kbi_evt,
    input  logic       rti_evt,
    output logic [1:0] mode,
    output logic       por_req,
    output logic       rst_req,
    output logic       illop_req,
    output logic       resume,
    output logic       cfg_stop_en,
    output logic       cfg_deep,
    output logic       cfg_partial,
    output logic       ppd_flag
);
    pcfg_t  cfg;
    pwake_t wake;
    pmode_t state;
    logic   wr_allow;
    logic   clr_all;
    logic   set_flag;

    stopsel_wake u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pol_high(irq_pol_high),
        .rst_pin_n   (rst_pin_n),
        .irq_pin     (irq_pin),
        .kbi_evt     (kbi_evt),
        .rti_evt     (rti_evt),
        .wake        (wake)
    );

    stopsel_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_allow   (wr_allow),
        .clr_all    (clr_all),
        .set_flag   (set_flag),
        .opt_wr     (opt_wr),
        .opt_stop_en(opt_stop_en),
        .pm_wr      (pm_wr),
        .pm_deep    (pm_deep),
        .pm_partial (pm_partial),
        .pm_ack     (pm_ack),
        .cfg        (cfg),
        .ppd_flag   (ppd_flag)
    );

    stopsel_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .lvd_stop_en(lvd_stop_en),
        .dbg_en     (dbg_en),
        .cfg        (cfg),
        .wake       (wake),
        .state      (state),
        .wr_allow   (wr_allow),
        .clr_all    (clr_all),
        .set_flag   (set_flag),
        .por_req    (por_req),
        .rst_req    (rst_req),
        .illop_req  (illop_req),
        .resume     (resume)
    );

    always_comb begin
        mode        = state;
        cfg_stop_en = cfg.stop_en;
        cfg_deep    = cfg.deep;
        cfg_partial = cfg.partial;
    end
endmodule

// File: rtl/stopsel_ctrl_chk.sv
module stopsel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       lvd_stop_en,
    input logic       dbg_en,
    input logic       rst_pin_n,
    input logic       irq_pin,
    input logic       rti_evt,
    input logic [1:0] mode,
    input logic       por_req,
    input logic       rst_req,
    input logic       illop_req,
    input logic       resume,
    input logic       cfg_stop_en,
    input logic       cfg_deep,
    input logic       cfg_partial,
    input logic       ppd_flag
);
    logic pin_prev;
    logic irq_prev;
    logic pin_f;
    logic irq_f;
    logic grant;
    logic any_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= 1'b1;
            irq_prev <= 1'b1;
        end else begin
            pin_prev <= rst_pin_n;
            irq_prev <= irq_pin;
        end
    end

    always_comb begin
        pin_f   = pin_prev && !rst_pin_n;
        irq_f   = irq_prev && !irq_pin;
        grant   = (mode == 2'd0) && stop_req && cfg_stop_en && !pin_f;
        any_rst = por_req || rst_req || illop_req;
    end

    a_r1_stop1: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !lvd_stop_en && !dbg_en && cfg_deep && !cfg_partial |=> mode == 2'd1);
    a_r1_stop2: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !lvd_stop_en && !dbg_en && cfg_deep && cfg_partial |=> mode == 2'd2);
    a_r1_stop3: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !cfg_deep |=> mode == 2'd3);
    a_r2_force_light: assert property (@(posedge clk) disable iff (!rst_n)
        grant && (lvd_stop_en || dbg_en) |=> mode == 2'd3);
    a_r3_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) && stop_req && !cfg_stop_en && !pin_f |=> illop_req && mode == 2'd0);
    a_r4_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stop_en |=> cfg_stop_en || any_rst);
    a_r5_stop1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) && !pin_f && !irq_f |=> mode == 2'd1);
    a_r5_stop1_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) && (pin_f || irq_f) |=> por_req && !ppd_flag && mode == 2'd0);
    a_r6_stop2_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) && (pin_f || irq_f || rti_evt) |=> por_req && ppd_flag && mode == 2'd0);
    a_r7_pin_in_stop3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) && pin_f |=> rst_req && mode == 2'd0);
    a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({por_req, rst_req, illop_req, resume}));
    a_r10_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |-> !cfg_stop_en && !cfg_deep && !cfg_partial);
    a_r11_run_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) && pin_f |=> rst_req && !ppd_flag && mode == 2'd0);
endmodule

bind stopsel_ctrl stopsel_ctrl_chk u_chk (.*);

// File: tb/stopsel_ctrl_bench.sv
module stopsel_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, opt_wr = 0, opt_stop_en = 0, pm_wr = 0, pm_deep = 0;
    logic pm_partial = 0, pm_ack = 0, lvd_stop_en = 0, dbg_en = 0, irq_pol_high = 0;
    logic rst_pin_n = 1, irq_pin = 1, kbi_evt = 0, rti_evt = 0;
    logic [1:0] mode;
    logic por_req, rst_req, illop_req, resume, cfg_stop_en, cfg_deep, cfg_partial, ppd_flag;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    int m_mode = 0;
    bit m_sen, m_swr, m_deep, m_part, m_pwr, m_flag;
    bit m_por, m_rst, m_ill, m_res, m_pinq = 1, m_irqq = 1;

    always #5 clk = ~clk;

    stopsel_ctrl u_stopsel_ctrl (.*);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_sen = 0; m_swr = 0; m_deep = 0; m_part = 0; m_pwr = 0;
            m_flag = 0; m_por = 0; m_rst = 0; m_ill = 0; m_res = 0; m_pinq = 1; m_irqq = 1;
        end else begin
            bit pf, irqf, irqc, clr, setf;
            pf   = m_pinq && !rst_pin_n;
            irqf = m_irqq && !irq_pin;
            irqc = irq_pol_high ? (!m_irqq && irq_pin) : irqf;
            clr = 0; setf = 0; m_por = 0; m_rst = 0; m_ill = 0; m_res = 0;
            if (m_mode == 0) begin
                if (pf) begin m_rst = 1; clr = 1; end
                else if (stop_req) begin
                    if (!m_sen) begin m_ill = 1; clr = 1; end
                    else if (lvd_stop_en || dbg_en || !m_deep) m_mode = 3;
                    else m_mode = m_part ? 2 : 1;
                end else begin
                    if (opt_wr && !m_swr) begin m_sen = opt_stop_en; m_swr = 1; end
                    if (pm_wr && !m_pwr) begin m_deep = pm_deep; m_part = pm_partial; m_pwr = 1; end
                    if (pm_wr && pm_ack) m_flag = 0;
                end
            end else if (m_mode == 1) begin
                if (pf || irqf) begin m_mode = 0; m_por = 1; clr = 1; end
            end else if (m_mode == 2) begin
                if (pf || irqf || rti_evt) begin m_mode = 0; m_por = 1; clr = 1; setf = 1; end
            end else begin
                if (pf) begin m_mode = 0; m_rst = 1; clr = 1; end
                else if (irqc || kbi_evt || rti_evt) begin m_mode = 0; m_res = 1; end
            end
            if (clr) begin
                m_sen = 0; m_swr = 0; m_deep = 0; m_part = 0; m_pwr = 0; m_flag = setf;
            end
            m_pinq = rst_pin_n;
            m_irqq = irq_pin;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (mode != m_mode[1:0] || por_req != m_por || rst_req != m_rst ||
                illop_req != m_ill || resume != m_res || cfg_stop_en != m_sen ||
                cfg_deep != m_deep || cfg_partial != m_part || ppd_flag != m_flag) begin
                fails++;
                $display("FAIL R10 model compare: act mode=%0d p%0b r%0b i%0b s%0b c%0b%0b%0b f%0b exp mode=%0d p%0b r%0b i%0b s%0b c%0b%0b%0b f%0b",
                    mode, por_req, rst_req, illop_req, resume, cfg_stop_en, cfg_deep, cfg_partial, ppd_flag,
                    m_mode, m_por, m_rst, m_ill, m_res, m_sen, m_deep, m_part, m_flag);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        stop_req = 0; opt_wr = 0; pm_wr = 0; pm_ack = 0; kbi_evt = 0; rti_evt = 0;
    endtask

    task automatic setup(input bit deep, input bit part);
        opt_wr = 1; opt_stop_en = 1; step();
        pm_wr = 1; pm_deep = deep; pm_partial = part; step();
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        chk("R10 reset mode", mode, 0);
        chk("R10 reset pulses", {por_req, rst_req, illop_req, resume, ppd_flag}, 0);
        // R3 illegal stop
        stop_req = 1; step();
        chk("R3 illop", illop_req, 1);
        chk("R3 mode run", mode, 0);
        step();
        chk("R3 pulse width", illop_req, 0);
        // R4 write-once
        setup(1, 0);
        opt_wr = 1; opt_stop_en = 0; step();
        chk("R4 enable kept", cfg_stop_en, 1);
        pm_wr = 1; pm_deep = 1; pm_partial = 1; step();
        chk("R4 partial kept", cfg_partial, 0);
        // R1 stop1, R5 ignores
        stop_req = 1; step();
        chk("R1 stop1", mode, 1);
        kbi_evt = 1; rti_evt = 1; step();
        chk("R5 kbi/rti ignored", mode, 1);
        irq_pol_high = 1; irq_pin = 0; step();
        chk("R5 irq exit por", por_req, 1);
        chk("R8 falling in stop1", mode, 0);
        chk("R5 no flag", ppd_flag, 0);
        chk("R10 cfg cleared", {cfg_stop_en, cfg_deep, cfg_partial}, 0);
        irq_pin = 1; step();
        // R6 stop2
        setup(1, 1);
        stop_req = 1; step();
        chk("R1 stop2", mode, 2);
        kbi_evt = 1; step();
        chk("R6 kbi ignored", mode, 2);
        rti_evt = 1; step();
        chk("R6 timer exit por", por_req, 1);
        chk("R6 flag set", ppd_flag, 1);
        // R9 ack
        pm_wr = 1; pm_ack = 1; pm_deep = 0; pm_partial = 1; step();
        chk("R9 flag cleared", ppd_flag, 0);
        pm_wr = 1; pm_ack = 1; step();
        chk("R9 ack after slot used", ppd_flag, 0);
        // R7 stop3 (deep = 0)
        opt_wr = 1; opt_stop_en = 1; step();
        stop_req = 1; step();
        chk("R1 stop3 deep0", mode, 3);
        rti_evt = 1; step();
        chk("R7 timer resume", resume, 1);
        stop_req = 1; step();
        irq_pin = 0; step();
        chk("R7 wrong polarity ignored", mode, 3);
        irq_pin = 1; step();
        chk("R7 rising resume", resume, 1);
        stop_req = 1; step();
        kbi_evt = 1; step();
        chk("R7 kbi resume", resume, 1);
        stop_req = 1; step();
        rst_pin_n = 0; step();
        chk("R7 pin reset", rst_req, 1);
        chk("R7 back to run", mode, 0);
        rst_pin_n = 1; step();
        // R2 forcing
        setup(1, 1);
        lvd_stop_en = 1; stop_req = 1; step();
        chk("R2 lvd forces stop3", mode, 3);
        kbi_evt = 1; lvd_stop_en = 0; dbg_en = 1; step();
        stop_req = 1; step();
        chk("R2 dbg forces stop3", mode, 3);
        kbi_evt = 1; dbg_en = 0; step();
        stop_req = 1; step();
        chk("R1 stop2 again", mode, 2);
        irq_pin = 0; step();
        chk("R8 falling in stop2", por_req, 1);
        chk("R6 flag via irq", ppd_flag, 1);
        irq_pin = 1; step();
        // R11 pin reset in run
        rst_pin_n = 0; step();
        chk("R11 rst_req", rst_req, 1);
        chk("R11 flag cleared", ppd_flag, 0);
        rst_pin_n = 1; step();
        // R8 rising ignored in stop1
        setup(1, 0);
        irq_pin = 0; step();
        stop_req = 1; step();
        chk("R1 stop1 again", mode, 1);
        irq_pin = 1; step();
        chk("R8 rising ignored", mode, 1);
        rst_pin_n = 0; step();
        chk("R5 pin exit por", por_req, 1);
        rst_pin_n = 1; step();
        step();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule